// File: doc/BRIEF.md
# Serial Transmit Front End with Memory Fetch

This block sits between a 32-bit register bus and a byte serializer. Software either writes one byte into the transmit holding register, or loads a memory pointer and then a byte count. The count write makes the block read that many bytes itself, one at a time, from consecutive system-memory addresses through a byte-read port. Every byte leaves on a valid/ready stream toward the serializer.

The register index is the word index of the bus address, so registers sit four bytes apart. A receive-count register sets a receive-buffer-ready flag when it holds a nonzero value. Control, mode, baud, timeout and guard-time writes are accepted and change nothing.

A block run drives a busy output. While busy is high, writes to the transmit registers (holding, pointer, count) are dropped. The pointer is cleared once every accepted count write has been handled. A second count write therefore sends nothing unless a new pointer is loaded first.

Top module: `serial_tx_fetch`

## Requirements
- R1: After reset, txValid, memReqValid, busy and rxReadyFlag are 0, and a read of index 15 returns 0.
- R2: While idle, a write to index 7 (byte address 0x1C) raises txValid in the next cycle, with txData equal to bits [7:0] of the write data. txValid and txData hold until the cycle in which txReady is sampled high. busy is high while this byte is pending.
- R3: A write to index 14 (0x38) stores a 32-bit pointer P. A later write of N to index 15 (0x3C) sends N bytes on the output, taken from memory addresses P, P+1, ... P+N-1 in that order. N is the low 16 bits of the write data.
- R4: Each fetch is a one-cycle memReqValid pulse carrying memReqAddr. The response (memRspValid with memRspData) may come one or more cycles later. The byte appears on txData in the cycle after the response. No new request is issued while a byte waits for txReady.
- R5: A write to index 15 while the stored pointer is zero sends nothing: no request is made, busy stays low, and index 15 reads 0.
- R6: Once a count write has been handled, the stored pointer is zero. This holds when the transfer completes, and also when the count is zero. A following count write with no new pointer sends nothing.
- R7: A write to index 13 (0x34) sets rxReadyFlag in the next cycle if any of the 32 data bits is 1, and clears it if the value is zero.
- R8: Writes to indices 0, 1, 8, 10 and 11 leave txValid, busy, rxReadyFlag and the index-15 read value unchanged.
- R9: While busy is high, writes to indices 7, 14 and 15 are ignored. The byte being sent, the bytes still to come and the remaining count all stay as they were.
- R10: A read of index 15 returns, zero-extended, the number of block bytes not yet accepted downstream. The value drops by one in the cycle after each accept and is 0 when the block is done. Reads of other indices return 0.
- R11: The index is taken from address bits [11:2], and bits [1:0] are ignored. For example, a write to byte address 0x1E acts as a write to index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 12 | Byte address; index is bits [11:2] |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (combinational) |
| memReqValid | output | 1 | One-cycle memory byte-read request |
| memReqAddr | output | 32 | Address of the requested byte |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 8 | Memory read data |
| txValid | output | 1 | Output byte valid |
| txData | output | 8 | Output byte |
| txReady | input | 1 | Serializer accepts the byte |
| rxReadyFlag | output | 1 | Receive count is nonzero |
| busy | output | 1 | A single byte or block run is in progress |

## Verification
The hardest case to reach is a register write that lands in the middle of a block run, while a fetched byte waits on a stalled output. The write has to change neither that byte nor the addresses still to be fetched. The bench stops its automatic sink and adds memory latency, so the run stalls on a known byte. It then writes the holding, pointer and count registers and checks that the pending byte, the remaining count and the later bytes are unchanged. A table of pointer, count, latency and back-pressure sets covers the normal runs, including a pointer that wraps through zero in the middle of a run.

// File: rtl/serial_tx_fetch_pkg.sv
package serial_tx_fetch_pkg;

  localparam int IDX_HOLD  = 7;
  localparam int IDX_RXCNT = 13;
  localparam int IDX_PTR   = 14;
  localparam int IDX_CNT   = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SINGLE,
    ST_REQ,
    ST_WAIT,
    ST_SEND
  } txState_e;

  typedef struct packed {
    logic loadPtr;
    logic loadCount;
    logic clearPtr;
    logic takeBusByte;
    logic takeMemByte;
    logic advance;
    logic loadRx;
  } dpStrobe_t;

endpackage

// File: rtl/serial_tx_fetch_ctrl.sv
module serial_tx_fetch_ctrl
  import serial_tx_fetch_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             ptrIsZero,
  input  logic             cntFieldZero,
  input  logic             countIsOne,
  input  logic             countIsZero,
  input  logic             memRspValid,
  input  logic             txReady,
  output dpStrobe_t        strobe,
  output logic             memReqValid,
  output logic             txValid,
  output logic             busy
);

  txState_e state, nextState;
  logic idle, wrHold, wrPtr, wrCnt, wrRx, startBlock, lastAccept;

  assign idle       = (state == ST_IDLE);
  assign wrHold     = wrEn && idle && (regIdx == IDX_W'(IDX_HOLD));
  assign wrPtr      = wrEn && idle && (regIdx == IDX_W'(IDX_PTR));
  assign wrCnt      = wrEn && idle && (regIdx == IDX_W'(IDX_CNT));
  assign wrRx       = wrEn && (regIdx == IDX_W'(IDX_RXCNT));
  assign startBlock = wrCnt && !ptrIsZero && !cntFieldZero;
  assign lastAccept = (state == ST_SEND) && txReady && countIsOne;

  always_comb begin
    strobe             = '0;
    strobe.loadPtr     = wrPtr;
    strobe.loadCount   = startBlock;
    strobe.clearPtr    = (wrCnt && !startBlock) || lastAccept;
    strobe.takeBusByte = wrHold;
    strobe.takeMemByte = (state == ST_WAIT) && memRspValid;
    strobe.advance     = (state == ST_SEND) && txReady;
    strobe.loadRx      = wrRx;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (wrHold)          nextState = ST_SINGLE;
        else if (startBlock) nextState = ST_REQ;
      end
      ST_SINGLE: if (txReady) nextState = ST_IDLE;
      ST_REQ:    nextState = ST_WAIT;
      ST_WAIT:   if (memRspValid) nextState = ST_SEND;
      ST_SEND:   if (txReady) nextState = countIsOne ? ST_IDLE : ST_REQ;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign memReqValid = (state == ST_REQ);
  assign txValid     = (state == ST_SINGLE) || (state == ST_SEND);
  assign busy        = !idle;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R4

  AST_END_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(state == ST_SEND)) |-> (countIsZero && ptrIsZero)); // R6

  AST_ZERO_PTR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && regIdx == IDX_W'(IDX_CNT) && ptrIsZero) |=> !busy); // R5

endmodule

// File: rtl/serial_tx_fetch_dp.sv
module serial_tx_fetch_dp
  import serial_tx_fetch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] memRspData,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] txByte,
  output logic              rxFlag,
  output logic [DATA_W-1:0] rdData,
  output logic              ptrIsZero,
  output logic              cntFieldZero,
  output logic              countIsOne,
  output logic              countIsZero
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      count  <= '0;
      txByte <= '0;
      rxFlag <= 1'b0;
    end else begin
      if (strobe.clearPtr)     ptr <= '0;
      else if (strobe.loadPtr) ptr <= wrData[PTR_W-1:0];
      else if (strobe.advance) ptr <= ptr + 1'b1;

      if (strobe.loadCount)    count <= wrData[CNT_W-1:0];
      else if (strobe.advance) count <= count - 1'b1;

      if (strobe.takeBusByte)      txByte <= wrData[BYTE_W-1:0];
      else if (strobe.takeMemByte) txByte <= memRspData;

      if (strobe.loadRx) rxFlag <= (wrData != '0);
    end
  end

  assign ptrIsZero    = (ptr == '0);
  assign cntFieldZero = (wrData[CNT_W-1:0] == '0);
  assign countIsOne   = (count == CNT_W'(1));
  assign countIsZero  = (count == '0);
  assign rdData       = (rdEn && regIdx == IDX_W'(IDX_CNT)) ? DATA_W'(count) : '0;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (count == $past(count) - 1'b1)); // R10

  AST_RX_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRx |=> (rxFlag == ($past(wrData) != '0))); // R7

endmodule

// File: rtl/serial_tx_fetch.sv
module serial_tx_fetch
  import serial_tx_fetch_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              memReqValid,
  output logic [PTR_W-1:0]  memReqAddr,
  input  logic              memRspValid,
  input  logic [BYTE_W-1:0] memRspData,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  output logic              rxReadyFlag,
  output logic              busy
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] regIdx;
  logic [1:0]       unusedAddrBits;
  dpStrobe_t        strobe;
  logic ptrIsZero, cntFieldZero, countIsOne, countIsZero;

  assign regIdx         = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = busAddr[1:0];

  serial_tx_fetch_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (busWrEn),
    .regIdx       (regIdx),
    .ptrIsZero    (ptrIsZero),
    .cntFieldZero (cntFieldZero),
    .countIsOne   (countIsOne),
    .countIsZero  (countIsZero),
    .memRspValid  (memRspValid),
    .txReady      (txReady),
    .strobe       (strobe),
    .memReqValid  (memReqValid),
    .txValid      (txValid),
    .busy         (busy)
  );

  serial_tx_fetch_dp #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (busWrData),
    .regIdx       (regIdx),
    .rdEn         (busRdEn),
    .memRspData   (memRspData),
    .ptr          (memReqAddr),
    .txByte       (txData),
    .rxFlag       (rxReadyFlag),
    .rdData       (busRdData),
    .ptrIsZero    (ptrIsZero),
    .cntFieldZero (cntFieldZero),
    .countIsOne   (countIsOne),
    .countIsZero  (countIsZero)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData))); // R2

endmodule

// File: tb/test_serial_tx_fetch.sv
module test_serial_tx_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic        memReqValid, memRspValid = 1'b0;
  logic [31:0] memReqAddr;
  logic [7:0]  memRspData = '0, txData;
  logic        txValid, txReady = 1'b0, rxReadyFlag, busy;

  int checks = 0, errors = 0;
  bit sinkAuto = 1'b0;
  int sinkDly = 0, respLat = 1;
  logic [31:0] reqLog [64];
  logic [7:0]  byteLog [64];
  int reqCnt = 0, byteCnt = 0, overlapCnt = 0;

  localparam int NVEC = 4;
  localparam logic [31:0] VEC_PTR [NVEC] = '{32'h0000_1000, 32'h0000_20FE, 32'hFFFF_FFFE, 32'h0000_0040};
  localparam int VEC_N   [NVEC] = '{1, 4, 3, 5};
  localparam int VEC_LAT [NVEC] = '{1, 3, 2, 4};
  localparam int VEC_DLY [NVEC] = '{0, 2, 1, 3};

  always #4 clk = ~clk;

  serial_tx_fetch i_serial_tx_fetch (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxReadyFlag(rxReadyFlag),
    .busy(busy)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] addr, input logic [31:0] d);
    busAddr = addr; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] addr, output logic [31:0] d);
    busAddr = addr; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic acceptOne();
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic waitValid();
    for (int n = 0; n < 200 && !txValid; n++) @(negedge clk);
  endtask

  // memory model: samples a request, answers after respLat cycles
  initial forever begin
    @(negedge clk);
    if (memReqValid) begin
      logic [7:0] d;
      reqLog[reqCnt % 64] = memReqAddr;
      reqCnt++;
      if (txValid) overlapCnt++;
      d = memByte(memReqAddr);
      @(negedge clk);
      repeat (respLat - 1) @(negedge clk);
      memRspData = d; memRspValid = 1'b1;
      @(negedge clk);
      memRspValid = 1'b0;
    end
  end

  // automatic sink with back-pressure
  initial forever begin
    @(negedge clk);
    if (sinkAuto && txValid) begin
      repeat (sinkDly) @(negedge clk);
      byteLog[byteCnt % 64] = txData;
      byteCnt++;
      txReady = 1'b1;
      @(negedge clk);
      txReady = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int reqBefore;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 txValid", 32'(txValid), 0);
    checkEq("R1 busy", 32'(busy), 0);
    checkEq("R1 memReqValid", 32'(memReqValid), 0);
    checkEq("R1 rxReadyFlag", 32'(rxReadyFlag), 0);
    busRead(12'h03C, rd);
    checkEq("R1 remaining", rd, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 single byte held under back-pressure
    busWrite(12'h01C, 32'h1234_56C3);
    checkEq("R2 txValid", 32'(txValid), 1);
    checkEq("R2 txData", 32'(txData), 32'hC3);
    checkEq("R2 busy", 32'(busy), 1);
    repeat (3) @(negedge clk);
    busWrite(12'h01C, 32'h55);   // R9 ignored while pending
    checkEq("R9 single pending hold", 32'(txData), 32'hC3);
    checkEq("R2 still valid", 32'(txValid), 1);
    acceptOne();
    checkEq("R2 valid drops", 32'(txValid), 0);
    checkEq("R2 busy drops", 32'(busy), 0);

    // R11 low address bits ignored
    busWrite(12'h01E, 32'h77);
    checkEq("R11 aliased write valid", 32'(txValid), 1);
    checkEq("R11 aliased write data", 32'(txData), 32'h77);
    acceptOne();

    // R7 receive count flag
    busWrite(12'h034, 32'd5);
    checkEq("R7 set", 32'(rxReadyFlag), 1);
    busWrite(12'h034, 32'd0);
    checkEq("R7 clear", 32'(rxReadyFlag), 0);
    busWrite(12'h034, 32'h8000_0000);
    checkEq("R7 upper bit", 32'(rxReadyFlag), 1);

    // R8 inert registers
    busWrite(12'h000, 32'hFFFF_FFFF);
    busWrite(12'h004, 32'hFFFF_FFFF);
    busWrite(12'h020, 32'hFFFF_FFFF);
    busWrite(12'h028, 32'hFFFF_FFFF);
    busWrite(12'h02C, 32'hFFFF_FFFF);
    @(negedge clk);
    checkEq("R8 txValid", 32'(txValid), 0);
    checkEq("R8 busy", 32'(busy), 0);
    checkEq("R8 flag", 32'(rxReadyFlag), 1);
    busRead(12'h03C, rd);
    checkEq("R8 remaining", rd, 0);
    busRead(12'h038, rd);
    checkEq("R10 other index reads zero", rd, 0);

    // R5 zero pointer
    reqBefore = reqCnt;
    busWrite(12'h03C, 32'd4);
    repeat (3) @(negedge clk);
    checkEq("R5 busy", 32'(busy), 0);
    checkEq("R5 no request", 32'(reqCnt), 32'(reqBefore));
    busRead(12'h03C, rd);
    checkEq("R5 remaining", rd, 0);

    // R3 R4 R10 table of block runs
    sinkAuto = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      reqCnt = 0; byteCnt = 0;
      respLat = VEC_LAT[v]; sinkDly = VEC_DLY[v];
      busWrite(12'h038, VEC_PTR[v]);
      busWrite(12'h03C, 32'(VEC_N[v]));
      checkEq("R9 busy during run", 32'(busy), 1);
      waitIdle();
      checkEq("R3 byte count", 32'(byteCnt), 32'(VEC_N[v]));
      for (int i = 0; i < VEC_N[v]; i++) begin
        checkEq("R3 byte value", 32'(byteLog[i]), 32'(memByte(VEC_PTR[v] + 32'(i))));
        checkEq("R4 request address", reqLog[i], VEC_PTR[v] + 32'(i));
      end
      busRead(12'h03C, rd);
      checkEq("R10 remaining at end", rd, 0);
    end
    checkEq("R4 no request while byte pending", 32'(overlapCnt), 0);

    // R6 pointer cleared after completion and after zero count
    reqBefore = reqCnt;
    busWrite(12'h03C, 32'd3);
    repeat (2) @(negedge clk);
    checkEq("R6 after completion", 32'(busy), 0);
    busWrite(12'h038, 32'h500);
    busWrite(12'h03C, 32'd0);
    checkEq("R6 zero count idle", 32'(busy), 0);
    busWrite(12'h03C, 32'd2);
    repeat (2) @(negedge clk);
    checkEq("R6 after zero count", 32'(busy), 0);
    checkEq("R6 no request", 32'(reqCnt), 32'(reqBefore));
    sinkAuto = 1'b0;

    // R9 R10 writes during a stalled run
    respLat = 2;
    busWrite(12'h038, 32'h300);
    busWrite(12'h03C, 32'd3);
    waitValid();
    busRead(12'h03C, rd);
    checkEq("R10 remaining before accept", rd, 3);
    checkEq("R3 first byte", 32'(txData), 32'(memByte(32'h300)));
    busWrite(12'h01C, 32'hAA);
    busWrite(12'h038, 32'h900);
    busWrite(12'h03C, 32'd9);
    checkEq("R9 pending byte kept", 32'(txData), 32'(memByte(32'h300)));
    busRead(12'h03C, rd);
    checkEq("R9 count kept", rd, 3);
    acceptOne();
    busRead(12'h03C, rd);
    checkEq("R10 remaining after accept", rd, 2);
    waitValid();
    checkEq("R9 pointer kept", 32'(txData), 32'(memByte(32'h301)));
    acceptOne();
    waitValid();
    checkEq("R9 third byte", 32'(txData), 32'(memByte(32'h302)));
    acceptOne();
    checkEq("R9 run ends", 32'(busy), 0);
    busRead(12'h03C, rd);
    checkEq("R10 remaining zero", rd, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule